// File: doc/BRIEF.md
# Per-Frame Horizontal Resolution Change Sequencer

This block sits between the frame timing generator and a hardened camera-serial transmitter controller. It changes the transmitted line width from one frame to the next. A change request carries the new line width. The block holds the request until the frame sync input shows vertical blanking. It then drives two dummy line-sync pulses of its own onto the line-sync output and holds the controller reset (active low) for the whole of the first pulse. At the end of that first pulse it loads the new width together with the matching horizontal porch pair. Once the second pulse is over, normal line timing passes through again. The block has no reset output for the physical layer, so that reset is never touched.

The porch pair for each width comes from a small table that the surrounding logic loads through a write port. Each table entry holds a line width, a front porch and a back porch. When no valid entry matches the new width, default porches are used. A busy flag is high from the cycle after the request is taken until the second dummy pulse ends. While the dummy sequence runs, the frame sync output is held low so that the next frame cannot start early.

The controller has five states. IDLE goes to WAIT when a request arrives. WAIT goes to PULSE1 when the frame sync input is low. PULSE1 goes to GAP after PULSE_CYC cycles, and GAP goes to PULSE2 after GAP_CYC cycles. After PULSE_CYC cycles, PULSE2 goes back to WAIT if another request is pending, and to IDLE otherwise.

Top module: `hres_change_seq`

## Requirements
- R1: After reset, the outputs are as follows: hres_out=DEF_HRES (640), hfp_out=DEF_HFP (30), hbp_out=DEF_HBP (70), busy=0 and ctrl_rst_n=1. In IDLE, hsync_out and vsync_out copy hsync_in and vsync_in.
- R2: busy rises in the cycle after chg_req is sampled high in IDLE. It stays high until the last cycle of the second dummy pulse, and it is low in the cycle after.
- R3: A request taken while vsync_in is high is held. While vsync_in stays high, hsync_out copies hsync_in, ctrl_rst_n stays 1, hres_out is unchanged and vsync_out copies vsync_in.
- R4: In WAIT, a cycle with vsync_in low is followed by the dummy sequence. The sequence is PULSE_CYC (3) cycles with hsync_out=1, then GAP_CYC (4) cycles with hsync_out=0, then PULSE_CYC cycles with hsync_out=1.
- R5: ctrl_rst_n is 0 exactly during the cycles of the first dummy pulse, and 1 at all other times.
- R6: hres_out takes the requested width at the clock edge that ends the first dummy pulse, so the new value is first seen in the first gap cycle. hres_out does not change at any other time.
- R7: hfp_out and hbp_out change in the same cycle as hres_out. They take the porches of the lowest-indexed valid table entry whose width equals the new width, and DEF_HFP/DEF_HBP when no entry matches.
- R8: During PULSE1, GAP and PULSE2, vsync_out is held at 0 whatever vsync_in does.
- R9: When several requests arrive before the update, only the width of the most recent one is applied.
- R10: A request that arrives after the update point, including in the update cycle itself, does not change the update in progress. After the second dummy pulse the block returns to WAIT with busy still high, and it runs a complete new sequence for that width.
- R11: With tbl_we=1, the entry at tbl_idx (0 to 3) is loaded with tbl_hres, tbl_hfp and tbl_hbp and marked valid. The new contents apply from the next change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chg_req | input | 1 | Resolution change request, one cycle |
| chg_hres | input | 16 | Requested line width, sampled with chg_req |
| vsync_in | input | 1 | Frame sync from the timing generator (low = vertical blanking) |
| hsync_in | input | 1 | Line sync from the timing generator |
| tbl_we | input | 1 | Porch table write enable |
| tbl_idx | input | 2 | Porch table entry index |
| tbl_hres | input | 16 | Line width key for the written entry |
| tbl_hfp | input | 12 | Front porch for the written entry |
| tbl_hbp | input | 12 | Back porch for the written entry |
| hres_out | output | 16 | Line width to the transmitter |
| hfp_out | output | 12 | Front porch in use |
| hbp_out | output | 12 | Back porch in use |
| vsync_out | output | 1 | Frame sync to the transmitter, held low during the dummy sequence |
| hsync_out | output | 1 | Line sync to the transmitter, with the dummy pulses merged in |
| ctrl_rst_n | output | 1 | Controller reset to the transmitter, active low |
| busy | output | 1 | High while a change is pending or in progress |

## Verification
The collision that matters is a new request arriving in the same cycle as the width update at the end of the first dummy pulse. At that edge the held width is loaded and the pending register is overwritten at the same moment. The bench raises chg_req on exactly that edge with a different width. It expects the first width to appear in the first gap cycle. It also expects busy to stay high through the end of the second pulse and a complete second dummy sequence to follow, which loads the later width and its porches. A second overlap drives vsync_in high during the dummy sequence, and the bench checks that vsync_out is released only when the block returns to IDLE.

// File: rtl/hres_seq_pkg.sv
package hres_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PULSE1,
        ST_GAP,
        ST_PULSE2
    } seq_state_t;
endpackage

// File: rtl/hres_porch_table.sv
module hres_porch_table #(
    parameter int HRES_W  = 16,
    parameter int PORCH_W = 12,
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [HRES_W-1:0]  w_hres,
    input  logic [PORCH_W-1:0] w_hfp,
    input  logic [PORCH_W-1:0] w_hbp,
    input  logic [HRES_W-1:0]  key,
    output logic               hit,
    output logic [PORCH_W-1:0] hfp,
    output logic [PORCH_W-1:0] hbp
);
    logic [NUM_ENT-1:0] ent_v;
    logic [NUM_ENT-1:0] match;
    logic [HRES_W-1:0]  ent_hres [NUM_ENT];
    logic [PORCH_W-1:0] ent_hfp  [NUM_ENT];
    logic [PORCH_W-1:0] ent_hbp  [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic               v_q;
        logic [HRES_W-1:0]  h_q;
        logic [PORCH_W-1:0] f_q;
        logic [PORCH_W-1:0] b_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                h_q <= '0;
                f_q <= '0;
                b_q <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                v_q <= 1'b1;
                h_q <= w_hres;
                f_q <= w_hfp;
                b_q <= w_hbp;
            end
        end

        assign ent_v[g]    = v_q;
        assign ent_hres[g] = h_q;
        assign ent_hfp[g]  = f_q;
        assign ent_hbp[g]  = b_q;
        assign match[g]    = v_q && (h_q == key);
    end

    // Lowest index wins when several entries carry the same width.
    always_comb begin
        hit = |match;
        hfp = '0;
        hbp = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hfp = ent_hfp[i];
                hbp = ent_hbp[i];
            end
        end
    end
endmodule

// File: rtl/hres_seq_fsm.sv
module hres_seq_fsm
    import hres_seq_pkg::*;
#(
    parameter int PULSE_CYC = 3,
    parameter int GAP_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       again,
    input  logic       blank,
    output seq_state_t state,
    output logic       upd_now
);
    localparam int LEN_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             last_p;
    logic             last_g;

    assign last_p  = (cnt == CNT_W'(PULSE_CYC - 1));
    assign last_g  = (cnt == CNT_W'(GAP_CYC - 1));
    assign upd_now = (state == ST_PULSE1) && last_p;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)  nxt = ST_WAIT;
            ST_WAIT:   if (blank)  nxt = ST_PULSE1;
            ST_PULSE1: if (last_p) nxt = ST_GAP;
            ST_GAP:    if (last_g) nxt = ST_PULSE2;
            ST_PULSE2: if (last_p) nxt = again ? ST_WAIT : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hres_change_seq.sv
module hres_change_seq
    import hres_seq_pkg::*;
#(
    parameter int HRES_W    = 16,
    parameter int PORCH_W   = 12,
    parameter int NUM_ENT   = 4,
    parameter int PULSE_CYC = 3,
    parameter int GAP_CYC   = 4,
    parameter int DEF_HRES  = 640,
    parameter int DEF_HFP   = 30,
    parameter int DEF_HBP   = 70,
    localparam int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chg_req,
    input  logic [HRES_W-1:0]  chg_hres,
    input  logic               vsync_in,
    input  logic               hsync_in,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [HRES_W-1:0]  tbl_hres,
    input  logic [PORCH_W-1:0] tbl_hfp,
    input  logic [PORCH_W-1:0] tbl_hbp,
    output logic [HRES_W-1:0]  hres_out,
    output logic [PORCH_W-1:0] hfp_out,
    output logic [PORCH_W-1:0] hbp_out,
    output logic               vsync_out,
    output logic               hsync_out,
    output logic               ctrl_rst_n,
    output logic               busy
);
    seq_state_t         state;
    logic               upd_now;
    logic [HRES_W-1:0]  pend_hres;
    logic               pend_v;
    logic               lut_hit;
    logic [PORCH_W-1:0] lut_hfp;
    logic [PORCH_W-1:0] lut_hbp;
    logic               vs_pass;

    hres_seq_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (chg_req),
        .again   (pend_v | chg_req),
        .blank   (!vsync_in),
        .state   (state),
        .upd_now (upd_now)
    );

    hres_porch_table #(
        .HRES_W  (HRES_W),
        .PORCH_W (PORCH_W),
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W)
    ) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .widx   (tbl_idx),
        .w_hres (tbl_hres),
        .w_hfp  (tbl_hfp),
        .w_hbp  (tbl_hbp),
        .key    (pend_hres),
        .hit    (lut_hit),
        .hfp    (lut_hfp),
        .hbp    (lut_hbp)
    );

    // Held request: the latest width wins; the valid flag is consumed at the update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_hres <= HRES_W'(DEF_HRES);
            pend_v    <= 1'b0;
        end else begin
            if (chg_req) pend_hres <= chg_hres;
            if (chg_req)      pend_v <= 1'b1;
            else if (upd_now) pend_v <= 1'b0;
        end
    end

    // Width and porches move together at the end of the first dummy pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hres_out <= HRES_W'(DEF_HRES);
            hfp_out  <= PORCH_W'(DEF_HFP);
            hbp_out  <= PORCH_W'(DEF_HBP);
        end else if (upd_now) begin
            hres_out <= pend_hres;
            hfp_out  <= lut_hit ? lut_hfp : PORCH_W'(DEF_HFP);
            hbp_out  <= lut_hit ? lut_hbp : PORCH_W'(DEF_HBP);
        end
    end

    always_comb begin
        hsync_out  = hsync_in;
        ctrl_rst_n = 1'b1;
        busy       = 1'b1;
        vs_pass    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                vs_pass = 1'b1;
            end
            ST_WAIT:   vs_pass = 1'b1;
            ST_PULSE1: begin
                hsync_out  = 1'b1;
                ctrl_rst_n = 1'b0;
            end
            ST_GAP:    hsync_out = 1'b0;
            ST_PULSE2: hsync_out = 1'b1;
            default:   ;
        endcase
    end

    assign vsync_out = vsync_in & vs_pass;
endmodule

// File: rtl/hres_change_seq_chk.sv
module hres_change_seq_chk #(
    parameter int HRES_W  = 16,
    parameter int PORCH_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chg_req,
    input logic               vsync_in,
    input logic               vsync_out,
    input logic               hsync_out,
    input logic               ctrl_rst_n,
    input logic               busy,
    input logic [HRES_W-1:0]  hres_out,
    input logic [PORCH_W-1:0] hfp_out,
    input logic [PORCH_W-1:0] hbp_out
);
    assert_idle_rst_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ctrl_rst_n);

    assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(chg_req));

    assert_rst_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rst_n |-> (hsync_out && busy));

    assert_hres_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hres_out != $past(hres_out)) |-> (!$past(ctrl_rst_n) && ctrl_rst_n));

    assert_porch_with_hres_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((hfp_out != $past(hfp_out)) || (hbp_out != $past(hbp_out)))
            |-> (!$past(ctrl_rst_n) && ctrl_rst_n));

    assert_vsync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_out |-> vsync_in);
endmodule

bind hres_change_seq hres_change_seq_chk #(
    .HRES_W  (HRES_W),
    .PORCH_W (PORCH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chg_req    (chg_req),
    .vsync_in   (vsync_in),
    .vsync_out  (vsync_out),
    .hsync_out  (hsync_out),
    .ctrl_rst_n (ctrl_rst_n),
    .busy       (busy),
    .hres_out   (hres_out),
    .hfp_out    (hfp_out),
    .hbp_out    (hbp_out)
);

// File: tb/hres_change_seq_tb.sv
module hres_change_seq_tb;
    localparam int P    = 3;
    localparam int G    = 4;
    localparam int DHR  = 640;
    localparam int DHFP = 30;
    localparam int DHBP = 70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chg_req = 1'b0;
    logic [15:0] chg_hres = '0;
    logic        vsync_in = 1'b0;
    logic        hsync_in = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_idx = '0;
    logic [15:0] tbl_hres = '0;
    logic [11:0] tbl_hfp = '0;
    logic [11:0] tbl_hbp = '0;
    logic [15:0] hres_out;
    logic [11:0] hfp_out;
    logic [11:0] hbp_out;
    logic        vsync_out, hsync_out, ctrl_rst_n, busy;

    int checks = 0;
    int errors = 0;
    int cur_hres = DHR;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hres_change_seq u_dut (
        .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .chg_hres(chg_hres),
        .vsync_in(vsync_in), .hsync_in(hsync_in), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_hres(tbl_hres), .tbl_hfp(tbl_hfp),
        .tbl_hbp(tbl_hbp), .hres_out(hres_out), .hfp_out(hfp_out),
        .hbp_out(hbp_out), .vsync_out(vsync_out), .hsync_out(hsync_out),
        .ctrl_rst_n(ctrl_rst_n), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Phase inside a dummy sequence whose PULSE1 starts at index s+1:
    // 1 first pulse, 2 gap, 3 second pulse, 0 outside.
    function automatic int phase(input int i, input int s);
        int r = i - s;
        if (r >= 1 && r <= P)                 return 1;
        if (r >= P + 1 && r <= P + G)         return 2;
        if (r >= P + G + 1 && r <= 2 * P + G) return 3;
        return 0;
    endfunction

    task automatic tbl_write(input int idx, input int h, input int f, input int b);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_hres = 16'(h);
        tbl_hfp = 12'(f); tbl_hbp = 12'(b);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Request in blanking; vsync_in raised during the sequence to probe R8.
    task automatic run_change(input int target, input int efp, input int ebp);
        int ph;
        @(negedge clk);
        vsync_in = 1'b0; hsync_in = 1'b0; chg_req = 1'b1; chg_hres = 16'(target);
        for (int i = 1; i <= 2 * P + G + 2; i++) begin
            @(negedge clk);
            ph = phase(i, 1);
            chk("R4 hsync_out", int'(hsync_out), int'(ph == 1 || ph == 3));
            chk("R5 ctrl_rst_n", int'(ctrl_rst_n), int'(ph != 1));
            chk("R2 busy", int'(busy), int'(i <= 2 * P + G + 1));
            chk("R6 hres_out", int'(hres_out), (i >= P + 2) ? target : cur_hres);
            chk("R8 vsync_out", int'(vsync_out), int'(i >= 4 && i >= 2 * P + G + 2));
            chg_req = 1'b0;
            if (i == 3) vsync_in = 1'b1;
        end
        chk("R7 hfp_out", int'(hfp_out), efp);
        chk("R7 hbp_out", int'(hbp_out), ebp);
        cur_hres = target;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ph;
        int s2;
        repeat (3) @(negedge clk);
        hsync_in = 1'b1; vsync_in = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hres_out", int'(hres_out), DHR);
        chk("R1 hfp_out", int'(hfp_out), DHFP);
        chk("R1 hbp_out", int'(hbp_out), DHBP);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ctrl_rst_n", int'(ctrl_rst_n), 1);
        chk("R1 hsync pass", int'(hsync_out), 1);
        chk("R1 vsync pass", int'(vsync_out), 1);

        // R11: load the table, then sweep every entry and one unmatched width.
        for (int e = 0; e < 4; e++) tbl_write(e, 800 + 160 * e, 8 + 4 * e, 24 + 8 * e);
        for (int e = 0; e < 4; e++) run_change(800 + 160 * e, 8 + 4 * e, 24 + 8 * e);
        run_change(1234, DHFP, DHBP);

        // R3 and R9: requests during an active frame are held; the last one wins.
        @(negedge clk);
        vsync_in = 1'b1; hsync_in = 1'b0; chg_req = 1'b1; chg_hres = 16'd960;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk("R3 busy", int'(busy), 1);
            chk("R3 ctrl_rst_n", int'(ctrl_rst_n), 1);
            chk("R3 hres_out", int'(hres_out), cur_hres);
            chk("R3 hsync_out", int'(hsync_out), int'(hsync_in));
            chk("R3 vsync_out", int'(vsync_out), 1);
            chg_req = (k == 3);
            chg_hres = (k == 3) ? 16'd1120 : 16'd960;
            hsync_in = k[0];
        end
        vsync_in = 1'b0; hsync_in = 1'b0; chg_req = 1'b0;
        for (int j = 1; j <= 2 * P + G + 1; j++) begin
            @(negedge clk);
            ph = phase(j, 0);
            chk("R4 hsync_out held", int'(hsync_out), int'(ph == 1 || ph == 3));
            chk("R5 ctrl_rst_n held", int'(ctrl_rst_n), int'(ph != 1));
            chk("R9 hres_out", int'(hres_out), (j >= P + 1) ? 1120 : cur_hres);
            chk("R2 busy held", int'(busy), int'(j <= 2 * P + G));
        end
        chk("R9 hfp_out", int'(hfp_out), 16);
        chk("R9 hbp_out", int'(hbp_out), 40);
        cur_hres = 1120;

        // R10: a second request lands on the update edge itself.
        s2 = 2 * P + G + 2;
        @(negedge clk);
        vsync_in = 1'b0; hsync_in = 1'b0; chg_req = 1'b1; chg_hres = 16'd1280;
        for (int i = 1; i <= s2 + 2 * P + G + 1; i++) begin
            @(negedge clk);
            ph = (phase(i, 1) != 0) ? phase(i, 1) : phase(i, s2);
            chk("R10 hsync_out", int'(hsync_out), int'(ph == 1 || ph == 3));
            chk("R10 ctrl_rst_n", int'(ctrl_rst_n), int'(ph != 1));
            chk("R10 busy", int'(busy), int'(i <= s2 + 2 * P + G));
            chk("R10 hres_out", int'(hres_out),
                (i >= s2 + P + 1) ? 800 : ((i >= P + 2) ? 1280 : cur_hres));
            chg_req = (i == P + 1);
            chg_hres = (i == P + 1) ? 16'd800 : 16'd1280;
        end
        chk("R10 hfp_out", int'(hfp_out), 8);
        chk("R10 hbp_out", int'(hbp_out), 24);
        cur_hres = 800;

        // R11 overwrite makes a former miss hit; R7 lowest index wins on duplicates.
        tbl_write(1, 1234, 100, 200);
        run_change(1234, 100, 200);
        tbl_write(3, 800, 55, 66);
        run_change(800, 8, 24);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule